// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Aligner

This block sits between a word-wide memory port and a register file and lets byte-addressed accesses of three sizes share that port. The memory always delivers and accepts a full word. The aligner picks the addressed byte or halfword from the read word and moves it to the bottom of the load result. It then fills the upper bits with zeros or with copies of the value's top bit. For stores it copies the low byte or halfword of the register into every lane of the outgoing word. It raises write strobes only for the lanes the access covers.

Which lanes an offset names depends on a byte-order input that can change at run time. With the input low (the default), offset 0 is the least significant lane. With it high, offset 0 is the most significant lane. All three outputs are registered, so a result appears one clock after its inputs. Alignment checking and the storage itself belong to other blocks. For halfword accesses the lowest address bit is ignored. For word accesses every offset bit is ignored.

Top module: `lsa_aligner`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next clock edge sets the load result, store data and strobes to zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge (one-cycle latency), back to back with no idle cycles.
- R3: A byte load with the signed flag low (size code 2'b00) returns the addressed byte in bits 7:0 and zeros in bits 31:8.
- R4: A byte load with the signed flag high copies bit 7 of the selected byte into bits 31:8.
- R5: A halfword load (size code 2'b01) with the signed flag low returns the selected halfword in bits 15:0 and zeros in bits 31:16. Offset bit 1 selects the halfword and offset bit 0 is ignored.
- R6: A halfword load with the signed flag high copies bit 15 of the selected halfword into bits 31:16.
- R7: A word load (size code 2'b10, and 2'b11 treated the same) returns the read word unchanged, whatever the offset, signed flag or byte order.
- R8: With byte order low, offset k maps to bits 8k+7:8k. With byte order high, offset 0 maps to bits 31:24 and halfword 0 to bits 31:16, with its more significant byte at the lower offset.
- R9: The store data holds the register's low byte in all four lanes for a byte store and its low halfword in both halves for a halfword store. For a word store it holds the register unchanged.
- R10: The strobes are bit-per-lane (bit k covers bits 8k+7:8k). With the store input high they mark one lane for a byte, two for a halfword and all four for a word. With the store input low they are all zero.
- R11: The store data for a word store of 0x11223344 is the same word. A byte load at offset 0 of that word returns 0x44 with byte order low and 0x11 with byte order high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_lo | input | 2 | Byte offset within the word |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| sext | input | 1 | Sign-extend the load result |
| big_end | input | 1 | Byte order select, 0 = least significant lane first |
| store | input | 1 | Access is a store (enables strobes) |
| rdata | input | 32 | Word read from memory |
| wdata | input | 32 | Register value to store |
| ld_result | output | 32 | Aligned, extended load value |
| st_data | output | 32 | Lane-replicated store word |
| st_strobe | output | 4 | Per-lane write enables |

## Verification
The bench sweeps every offset, size, signed setting, byte order and store flag over read words whose lane bytes all differ and have mixed top bits. A lane mapping wrongly mirrored in either byte order then returns a wrong byte rather than a matching one. Sign bytes of 0x80 and 0x7F in the selected lane catch extension that uses the wrong bit or always zero-fills. Halfword accesses at odd offsets catch a design that lets offset bit 0 move the selection. Loads with the store input low catch strobes that leak onto read cycles. Back-to-back vectors and a reset pulse in mid-run catch a design that adds or drops a cycle of latency or resets only part of its outputs.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Access size encoding carried on the size port
    typedef enum logic [1:0] {
        XFER_BYTE = 2'b00,
        XFER_HALF = 2'b01,
        XFER_WORD = 2'b10,
        XFER_WIDE = 2'b11   // treated as a word access
    } xfer_size_e;

    // Control bundle carried through the datapath
    typedef struct packed {
        xfer_size_e size;
        logic       sext;
        logic       big_end;
        logic       store;
    } xfer_ctl_t;

    localparam int unsigned LANE_W = 8;

    // Reduce the reserved code onto the word case
    function automatic xfer_size_e norm_size(input logic [1:0] raw);
        xfer_size_e s;
        s = xfer_size_e'(raw);
        if (s == XFER_WIDE) s = XFER_WORD;
        return s;
    endfunction

endpackage

// File: rtl/lsa_lane_map.sv
module lsa_lane_map
    import lsa_pkg::*;
#(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned OFF_W     = $clog2(NUM_LANES),
    parameter int unsigned HSEL_W    = OFF_W - 1
) (
    input  logic [OFF_W-1:0]     offset,
    input  xfer_ctl_t            ctl,
    output logic [OFF_W-1:0]     byte_lane,
    output logic [HSEL_W-1:0]    half_slot,
    output logic [NUM_LANES-1:0] lane_mask
);
    localparam int unsigned NUM_HALVES = NUM_LANES / 2;

    logic [HSEL_W-1:0] half_idx;

    always_comb begin
        half_idx = offset[OFF_W-1:1];
        if (ctl.big_end) begin
            byte_lane = OFF_W'(NUM_LANES - 1) - offset;
            half_slot = HSEL_W'(NUM_HALVES - 1) - half_idx;
        end else begin
            byte_lane = offset;
            half_slot = half_idx;
        end
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic hit;
        always_comb begin
            unique case (ctl.size)
                XFER_BYTE: hit = (OFF_W'(i) == byte_lane);
                XFER_HALF: hit = (HSEL_W'(i / 2) == half_slot);
                default:   hit = 1'b1;
            endcase
        end
        assign lane_mask[i] = hit & ctl.store;
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_LANES = DATA_W / LANE_W,
    parameter int unsigned OFF_W     = $clog2(NUM_LANES),
    parameter int unsigned HSEL_W    = OFF_W - 1
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  byte_lane,
    input  logic [HSEL_W-1:0] half_slot,
    input  xfer_ctl_t         ctl,
    output logic [DATA_W-1:0] result
);
    localparam int unsigned NUM_HALVES = NUM_LANES / 2;
    localparam int unsigned HALF_W     = 2 * LANE_W;

    logic [LANE_W-1:0] lane_bytes [NUM_LANES];
    logic [HALF_W-1:0] lane_halves [NUM_HALVES];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_bytes
        assign lane_bytes[i] = rdata[i*LANE_W +: LANE_W];
    end
    for (genvar j = 0; j < NUM_HALVES; j++) begin : g_halves
        assign lane_halves[j] = rdata[j*HALF_W +: HALF_W];
    end

    logic [LANE_W-1:0] pick_b;
    logic [HALF_W-1:0] pick_h;
    logic              fill;

    always_comb begin
        pick_b = lane_bytes[byte_lane];
        pick_h = lane_halves[half_slot];
        unique case (ctl.size)
            XFER_BYTE: begin
                fill   = ctl.sext & pick_b[LANE_W-1];
                result = {{(DATA_W-LANE_W){fill}}, pick_b};
            end
            XFER_HALF: begin
                fill   = ctl.sext & pick_h[HALF_W-1];
                result = {{(DATA_W-HALF_W){fill}}, pick_h};
            end
            default: begin
                fill   = 1'b0;
                result = rdata;
            end
        endcase
    end

endmodule

// File: rtl/lsa_store_replicate.sv
module lsa_store_replicate
    import lsa_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] wdata,
    input  xfer_ctl_t         ctl,
    output logic [DATA_W-1:0] rep_data
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_comb begin
            unique case (ctl.size)
                XFER_BYTE: rep_data[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                XFER_HALF: rep_data[i*LANE_W +: LANE_W] = wdata[(i%2)*LANE_W +: LANE_W];
                default:   rep_data[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
            endcase
        end
    end

endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_LANES = DATA_W / LANE_W,
    parameter int unsigned OFF_W     = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OFF_W-1:0]     addr_lo,
    input  logic [1:0]           size,
    input  logic                 sext,
    input  logic                 big_end,
    input  logic                 store,
    input  logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    ld_result,
    output logic [DATA_W-1:0]    st_data,
    output logic [NUM_LANES-1:0] st_strobe
);
    localparam int unsigned HSEL_W = OFF_W - 1;

    xfer_ctl_t             ctl;
    logic [OFF_W-1:0]      byte_lane;
    logic [HSEL_W-1:0]     half_slot;
    logic [NUM_LANES-1:0]  lane_mask;
    logic [DATA_W-1:0]     ld_next;
    logic [DATA_W-1:0]     st_next;

    always_comb begin
        ctl.size    = norm_size(size);
        ctl.sext    = sext;
        ctl.big_end = big_end;
        ctl.store   = store;
    end

    lsa_lane_map #(
        .NUM_LANES(NUM_LANES), .OFF_W(OFF_W), .HSEL_W(HSEL_W)
    ) u_map (
        .offset(addr_lo), .ctl(ctl),
        .byte_lane(byte_lane), .half_slot(half_slot), .lane_mask(lane_mask)
    );

    lsa_load_extract #(
        .DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .OFF_W(OFF_W), .HSEL_W(HSEL_W)
    ) u_load (
        .rdata(rdata), .byte_lane(byte_lane), .half_slot(half_slot),
        .ctl(ctl), .result(ld_next)
    );

    lsa_store_replicate #(
        .DATA_W(DATA_W), .NUM_LANES(NUM_LANES)
    ) u_store (
        .wdata(wdata), .ctl(ctl), .rep_data(st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_result <= '0;
            st_data   <= '0;
            st_strobe <= '0;
        end else begin
            ld_result <= ld_next;
            st_data   <= st_next;
            st_strobe <= lane_mask;
        end
    end

endmodule

module lsa_aligner_chk
    import lsa_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_LANES = DATA_W / LANE_W,
    parameter int unsigned OFF_W     = $clog2(NUM_LANES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [OFF_W-1:0]     addr_lo,
    input logic [1:0]           size,
    input logic                 sext,
    input logic                 big_end,
    input logic                 store,
    input logic [DATA_W-1:0]    rdata,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    ld_result,
    input logic [DATA_W-1:0]    st_data,
    input logic [NUM_LANES-1:0] st_strobe
);
    // R1: a sampled reset clears every output at the next edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (ld_result == '0 && st_data == '0 && st_strobe == '0));

    // R10: no strobes on a load
    assert_load_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(store)) |-> st_strobe == '0);

    // R10: strobe count follows the size
    assert_strobe_count_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(store)) |->
            $countones(st_strobe) == (($past(size) == 2'b00) ? 1 :
                                      ($past(size) == 2'b01) ? 2 : NUM_LANES));

    // R8: byte store in the default order strobes the lane equal to the offset
    assert_le_byte_lane_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(store) && $past(size) == 2'b00 && !$past(big_end)) |->
            st_strobe == (NUM_LANES'(1) << $past(addr_lo)));

    // R3: unsigned byte loads clear the upper bits
    assert_ubyte_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size) == 2'b00 && !$past(sext)) |->
            ld_result[DATA_W-1:8] == '0);

    // R4: signed byte loads copy bit 7 upward
    assert_sbyte_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size) == 2'b00 && $past(sext)) |->
            ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}});

    // R5: unsigned halfword loads clear the upper bits
    assert_uhalf_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size) == 2'b01 && !$past(sext)) |->
            ld_result[DATA_W-1:16] == '0);

    // R6: signed halfword loads copy bit 15 upward
    assert_shalf_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size) == 2'b01 && $past(sext)) |->
            ld_result[DATA_W-1:16] == {(DATA_W-16){ld_result[15]}});

    // R7: word loads pass the read word through
    assert_word_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size[1])) |-> ld_result == $past(rdata));

    // R9: byte stores replicate the low register byte in every lane
    assert_byte_repl_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(size) == 2'b00) |->
            st_data == {NUM_LANES{$past(wdata[7:0])}});

endmodule

bind lsa_aligner lsa_aligner_chk #(
    .DATA_W(DATA_W), .NUM_LANES(NUM_LANES), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .addr_lo(addr_lo), .size(size), .sext(sext),
    .big_end(big_end), .store(store), .rdata(rdata), .wdata(wdata),
    .ld_result(ld_result), .st_data(st_data), .st_strobe(st_strobe)
);

// File: tb/sim_lsa_aligner.sv
`timescale 1ns/1ps
module sim_lsa_aligner;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  addr_lo;
    logic [1:0]  size;
    logic        sext;
    logic        big_end;
    logic        store;
    logic [31:0] rdata;
    logic [31:0] wdata;
    logic [31:0] ld_result;
    logic [31:0] st_data;
    logic [3:0]  st_strobe;

    always #10 clk = ~clk;   // 50 MHz

    lsa_aligner u0 (
        .clk(clk), .rst(rst), .addr_lo(addr_lo), .size(size), .sext(sext),
        .big_end(big_end), .store(store), .rdata(rdata), .wdata(wdata),
        .ld_result(ld_result), .st_data(st_data), .st_strobe(st_strobe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected results waiting one cycle
    logic [31:0] q_ld [$];
    logic [31:0] q_sd [$];
    logic [3:0]  q_sb [$];
    string       q_tag [$];

    function automatic logic [7:0] mem_byte(logic [31:0] w, int off, bit be);
        int pos;
        pos = be ? (3 - off) : off;
        return w[8*pos +: 8];
    endfunction

    function automatic logic [31:0] ref_load(logic [31:0] w, int off, int sz, bit sx, bit be);
        logic [7:0]  b;
        logic [15:0] h;
        int base;
        if (sz == 0) begin
            b = mem_byte(w, off, be);
            return sx ? {{24{b[7]}}, b} : {24'h0, b};
        end else if (sz == 1) begin
            base = off & 2;
            if (be) h = {mem_byte(w, base, be), mem_byte(w, base + 1, be)};
            else    h = {mem_byte(w, base + 1, be), mem_byte(w, base, be)};
            return sx ? {{16{h[15]}}, h} : {16'h0, h};
        end
        return w;
    endfunction

    function automatic logic [31:0] ref_sdata(logic [31:0] d, int sz);
        if (sz == 0) return {4{d[7:0]}};
        if (sz == 1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [3:0] ref_strobe(int off, int sz, bit be, bit st);
        logic [3:0] m;
        int first, cnt;
        m = 4'h0;
        if (!st) return m;
        if (sz == 0)      begin first = off;     cnt = 1; end
        else if (sz == 1) begin first = off & 2; cnt = 2; end
        else              begin first = 0;       cnt = 4; end
        for (int k = first; k < first + cnt; k++)
            m[be ? 3 - k : k] = 1'b1;
        return m;
    endfunction

    function automatic string load_tag(int sz, bit sx);
        if (sz == 0) return sx ? "R4" : "R3";
        if (sz == 1) return sx ? "R6" : "R5";
        return "R7";
    endfunction

    task automatic compare_pending();
        string t;
        logic [31:0] el, ed;
        logic [3:0]  es;
        if (q_ld.size() == 0) return;
        el = q_ld.pop_front(); ed = q_sd.pop_front();
        es = q_sb.pop_front(); t = q_tag.pop_front();
        checks += 3;
        if (ld_result !== el) begin
            fails++;
            $display("FAIL %s load result: got %h expected %h", t, ld_result, el);
        end
        if (st_data !== ed) begin
            fails++;
            $display("FAIL %s/R9 store data: got %h expected %h", t, st_data, ed);
        end
        if (st_strobe !== es) begin
            fails++;
            $display("FAIL %s/R10 strobes: got %b expected %b", t, st_strobe, es);
        end
    endtask

    // One vector per clock: check the previous result, then drive the next
    task automatic step(bit r, int off, int sz, bit sx, bit be, bit st,
                        logic [31:0] rd, logic [31:0] wd, string tag);
        @(negedge clk);
        compare_pending();
        rst = r; addr_lo = 2'(off); size = 2'(sz); sext = sx;
        big_end = be; store = st; rdata = rd; wdata = wd;
        if (r) begin
            q_ld.push_back(32'h0); q_sd.push_back(32'h0); q_sb.push_back(4'h0);
            q_tag.push_back("R1");
        end else begin
            q_ld.push_back(ref_load(rd, off, sz, sx, be));
            q_sd.push_back(ref_sdata(wd, sz));
            q_sb.push_back(ref_strobe(off, sz, be, st));
            q_tag.push_back(tag);
        end
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h11223344;
        pats[1] = 32'h80F17F02;
        pats[2] = 32'h7F8001FE;
        pats[3] = 32'hA55A3CC3;

        // R1: reset with active inputs
        step(1, 1, 0, 1, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1");
        step(1, 3, 2, 0, 1, 1, 32'hDEADBEEF, 32'h12345678, "R1");

        // R11: the word-store / byte-load example in both orders
        step(0, 0, 2, 0, 0, 1, 32'h0, 32'h11223344, "R11");
        step(0, 0, 0, 0, 0, 0, 32'h11223344, 32'h0, "R11");
        step(0, 0, 0, 0, 1, 0, 32'h11223344, 32'h0, "R11");

        // R8: big-endian halfword 0 is bits 31:16, byte 0 is bits 31:24
        step(0, 0, 1, 0, 1, 1, 32'hABCD1234, 32'h00005566, "R8");
        step(0, 1, 1, 1, 1, 1, 32'hABCD1234, 32'h00005566, "R8");
        step(0, 2, 1, 0, 1, 1, 32'hABCD1234, 32'h00005566, "R8");
        step(0, 0, 0, 1, 1, 1, 32'h9A000000, 32'h000000C7, "R8");

        // R7: reserved size code behaves as a word
        step(0, 3, 3, 1, 1, 1, 32'h89ABCDEF, 32'h01234567, "R7");

        // R2: back-to-back alternating vectors
        for (int i = 0; i < 8; i++)
            step(0, i % 4, i % 3, i[0], i[1], i[2],
                 pats[i % 4], ~pats[(i + 1) % 4], "R2");

        // Full sweep of the control space
        for (int p = 0; p < 4; p++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 4; off++)
                    for (int m = 0; m < 8; m++)
                        step(0, off, sz, m[0], m[1], m[2],
                             pats[p], pats[(p + 1) % 4] ^ 32'h5A5A5A5A,
                             load_tag(sz, m[0]));

        // R1: reset pulse in mid-run, then recovery
        step(1, 2, 1, 1, 0, 1, 32'h8000FFFF, 32'hFFFF8000, "R1");
        step(0, 2, 1, 1, 0, 1, 32'h8000FFFF, 32'hFFFF8000, "R6");

        @(negedge clk);
        compare_pending();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule